// File: doc/BRIEF.md
# Serial Control and Status Shift Port

This block is the serial slave port of a twelve-channel load-driver controller. A host selects the port by pulling chip select low. It then clocks in a 16-bit control word, least significant bit first, and reads back a 16-bit status word on the data-out line during the same frame. The serial pins are asynchronous to the block. They pass through two-flop synchronisers, and all edge detection runs in a system clock domain that is at least eight times faster than the serial clock.

A received word reaches the parallel control register only when chip select rises and only when the frame held exactly sixteen falling serial-clock edges. Any other count leaves the register as it was. Because of this rule, a host can drop chip select, read status bit 0 (the temperature prewarning) straight from data-out without clocking, and raise chip select again with no side effect.

The status word is captured when chip select falls, so it stays fixed for the whole frame. The control register is also decoded into per-channel low-side and high-side enables, an open-load detection enable, a delay select, a run flag and a one-cycle status-reset pulse for the downstream logic.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset, `ctrl_o` is 0xE000 (bits 15, 14 and 13 high, the rest low), and `sdo_oe_o`, `ctrl_stb_o` and `stat_rst_o` are low.
- R2: `sdo_oe_o` is high while a frame is open, that is after a synchronised chip-select fall and before the following rise, and low at all other times.
- R3: Serial input is sampled on each falling serial-clock edge of a frame. The first sampled bit becomes bit 0 of the received word and the sixteenth becomes bit 15.
- R4: Straight after chip select falls, and before any clock edge, `sdo_d_o` shows captured status bit 0. After the n-th falling serial-clock edge, the next rising edge moves `sdo_d_o` to status bit n. `sdo_d_o` changes at no other time during a frame.
- R5: The status word presented to `sdo_d_o` is the value `status_i` held when chip select fell. Changes to `status_i` during the frame have no effect on it.
- R6: `ctrl_o` changes only in the cycle after a chip-select rise that ends an accepted frame. In that cycle `ctrl_stb_o` is high for exactly one cycle.
- R7: A frame with any count of falling serial-clock edges other than 16 leaves `ctrl_o` unchanged and produces no `ctrl_stb_o`. This includes a frame with zero edges (the prewarning read) and frames with more than 16 edges.
- R8: Serial-clock and data-in activity while chip select is high has no effect on `ctrl_o`, `ctrl_stb_o`, `sdo_oe_o` or the next frame.
- R9: The decoded outputs follow the control register as follows. `ls_on_o[k]` = bit 2k+1 and `hs_on_o[k]` = bit 2k+2, for k = 0 to 5. `old_en_o` = NOT bit 13, `long_dly_o` = bit 14 and `run_o` = bit 15. `stat_rst_o` is high only together with `ctrl_stb_o`, and only when bit 0 of the accepted word is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| status_i | input | 16 | Parallel status word to be returned |
| sdo_d_o | output | 1 | Serial data-out value |
| sdo_oe_o | output | 1 | Data-out drive enable; pad is high-impedance when low |
| ctrl_o | output | 16 | Control register |
| ctrl_stb_o | output | 1 | One-cycle pulse when a new control word is applied |
| stat_rst_o | output | 1 | One-cycle status-reset pulse |
| ls_on_o | output | 6 | Low-side enables, channels 1 to 6 |
| hs_on_o | output | 6 | High-side enables, channels 1 to 6 |
| old_en_o | output | 1 | Open-load detection enable |
| long_dly_o | output | 1 | Long short-circuit/undervoltage delay select |
| run_o | output | 1 | Software run flag (low means standby) |

## Verification
The hardest case to reach from the ports is a frame whose edge count is close to sixteen but not equal to it. Such a frame still shifts data and advances data-out like a valid frame, but it must not change the control register. The bench sweeps every clock count from 0 to 20. In each frame it drives a distinct word, checks every data-out bit against the captured status, and changes `status_i` part-way through to test the capture. The zero-count frame covers the prewarning read, and a burst of serial clocks with chip select high is followed by a valid frame to show the bit counter was not affected.

// File: rtl/ser_ctl_port.sv
module ser_ctl_port #(
  parameter int CHAN = 6,
  parameter int SYNC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n_i,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  input  logic [2*CHAN+3:0]     status_i,
  output logic                  sdo_d_o,
  output logic                  sdo_oe_o,
  output logic [2*CHAN+3:0]     ctrl_o,
  output logic                  ctrl_stb_o,
  output logic                  stat_rst_o,
  output logic [CHAN-1:0]       ls_on_o,
  output logic [CHAN-1:0]       hs_on_o,
  output logic                  old_en_o,
  output logic                  long_dly_o,
  output logic                  run_o
);
  localparam int WORD_W  = 2*CHAN + 4;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int OLD_BIT = 2*CHAN + 1;
  localparam int DLY_BIT = 2*CHAN + 2;
  localparam int RUN_BIT = 2*CHAN + 3;
  localparam logic [WORD_W-1:0] CTRL_RST = {3'b111, {(WORD_W-3){1'b0}}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0]  CNT_OK   = CNT_W'(WORD_W);

  logic [SYNC-1:0]   cs_pipe, sck_pipe, sdi_pipe;
  logic              cs_d, sck_d;
  logic              cs_s, sck_s, sdi_s;
  logic              cs_fall, cs_rise, sck_fall, sck_rise;
  logic [WORD_W-1:0] rx_sr, tx_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              adv;

  assign cs_s  = cs_pipe[SYNC-1];
  assign sck_s = sck_pipe[SYNC-1];
  assign sdi_s = sdi_pipe[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe  <= '1;
      sck_pipe <= '0;
      sdi_pipe <= '0;
      cs_d     <= 1'b1;
      sck_d    <= 1'b0;
    end else begin
      cs_pipe  <= {cs_pipe[SYNC-2:0], cs_n_i};
      sck_pipe <= {sck_pipe[SYNC-2:0], sclk_i};
      sdi_pipe <= {sdi_pipe[SYNC-2:0], sdi_i};
      cs_d     <= cs_s;
      sck_d    <= sck_s;
    end
  end

  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  assign sck_fall = sdo_oe_o & sck_d & ~sck_s;
  assign sck_rise = sdo_oe_o & ~sck_d & sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_oe_o   <= 1'b0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      bit_cnt    <= '0;
      adv        <= 1'b0;
      ctrl_o     <= CTRL_RST;
      ctrl_stb_o <= 1'b0;
    end else begin
      ctrl_stb_o <= 1'b0;
      if (cs_fall) begin
        sdo_oe_o <= 1'b1;
        tx_sr    <= status_i;
        bit_cnt  <= '0;
        adv      <= 1'b0;
      end else if (cs_rise) begin
        sdo_oe_o <= 1'b0;
        if (bit_cnt == CNT_OK) begin
          ctrl_o     <= rx_sr;
          ctrl_stb_o <= 1'b1;
        end
      end else begin
        if (sck_fall) begin
          rx_sr <= {sdi_s, rx_sr[WORD_W-1:1]};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
          adv <= 1'b1;
        end
        if (sck_rise && adv) begin
          tx_sr <= {1'b0, tx_sr[WORD_W-1:1]};
          adv   <= 1'b0;
        end
      end
    end
  end

  assign sdo_d_o    = tx_sr[0];
  assign stat_rst_o = ctrl_stb_o & ctrl_o[0];
  assign old_en_o   = ~ctrl_o[OLD_BIT];
  assign long_dly_o = ctrl_o[DLY_BIT];
  assign run_o      = ctrl_o[RUN_BIT];

  for (genvar k = 0; k < CHAN; k++) begin : g_chan
    assign ls_on_o[k] = ctrl_o[2*k+1];
    assign hs_on_o[k] = ctrl_o[2*k+2];
  end
endmodule

// File: rtl/ser_ctl_port_chk.sv
module ser_ctl_port_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo_d_o,
  input logic              sdo_oe_o,
  input logic [WORD_W-1:0] ctrl_o,
  input logic              ctrl_stb_o,
  input logic              stat_rst_o,
  input logic              sck_rise,
  input logic [CNT_W-1:0]  bit_cnt
);
  AST_CTRL_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> ctrl_stb_o); // R6
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb_o |=> !ctrl_stb_o); // R6
  AST_STB_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb_o |-> (!sdo_oe_o && $past(sdo_oe_o))); // R6
  AST_STB_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb_o |-> ($past(bit_cnt) == CNT_W'(WORD_W))); // R7
  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(sck_rise)) |-> $stable(sdo_d_o)); // R4
  AST_STATRST_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rst_o |-> ctrl_stb_o); // R9
endmodule

bind ser_ctl_port ser_ctl_port_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_d_o(sdo_d_o), .sdo_oe_o(sdo_oe_o),
  .ctrl_o(ctrl_o), .ctrl_stb_o(ctrl_stb_o), .stat_rst_o(stat_rst_o),
  .sck_rise(sck_rise), .bit_cnt(bit_cnt)
);

// File: tb/ser_ctl_port_tb.sv
module ser_ctl_port_tb;
  logic        clk = 0, rst_n = 0;
  logic        cs_n = 1, sclk = 0, sdi = 0;
  logic [15:0] status = 0;
  logic        sdo_d, sdo_oe, ctrl_stb, stat_rst, old_en, long_dly, run;
  logic [15:0] ctrl;
  logic [5:0]  ls_on, hs_on;
  int checks = 0, errors = 0;
  int stb_seen = 0, srst_seen = 0;
  bit done = 0;
  logic [15:0] exp_ctrl = 16'hE000;

  always #5 clk = ~clk;

  ser_ctl_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .status_i(status), .sdo_d_o(sdo_d), .sdo_oe_o(sdo_oe), .ctrl_o(ctrl),
    .ctrl_stb_o(ctrl_stb), .stat_rst_o(stat_rst), .ls_on_o(ls_on), .hs_on_o(hs_on),
    .old_en_o(old_en), .long_dly_o(long_dly), .run_o(run)
  );

  always @(negedge clk) begin
    if (ctrl_stb) stb_seen++;
    if (stat_rst) srst_seen++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_decode();
    logic [5:0] el, eh;
    for (int k = 0; k < 6; k++) begin
      el[k] = exp_ctrl[2*k+1];
      eh[k] = exp_ctrl[2*k+2];
    end
    chk(ls_on == el, "R9 ls", ls_on, el);
    chk(hs_on == eh, "R9 hs", hs_on, eh);
    chk({run, long_dly, old_en} == {exp_ctrl[15], exp_ctrl[14], ~exp_ctrl[13]}, "R9 mode",
        {run, long_dly, old_en}, {exp_ctrl[15], exp_ctrl[14], ~exp_ctrl[13]});
  endtask

  task automatic frame(input int nfall, input logic [15:0] word, input logic [15:0] st);
    int exp_stb;
    status = st;
    @(negedge clk) cs_n = 0;
    settle();
    chk(sdo_oe == 1'b1, "R2 oe in frame", sdo_oe, 1);
    chk(sdo_d == st[0], "R4 bit0 before clock", sdo_d, st[0]);
    status = ~st;
    for (int i = 0; i < nfall; i++) begin
      sdi = word[i % 16];
      @(negedge clk) sclk = 1;
      settle();
      if (i < 16) chk(sdo_d == st[i], "R4 R5 sdo bit", sdo_d, st[i]);
      @(negedge clk) sclk = 0;
      settle();
    end
    chk(ctrl == exp_ctrl, "R6 no early update", ctrl, exp_ctrl);
    stb_seen = 0; srst_seen = 0;
    @(negedge clk) cs_n = 1;
    settle(); settle();
    chk(sdo_oe == 1'b0, "R2 oe after frame", sdo_oe, 0);
    exp_stb = (nfall == 16) ? 1 : 0;
    if (nfall == 16) exp_ctrl = word;
    chk(stb_seen == exp_stb, (nfall == 16) ? "R6 strobe" : "R7 no strobe", stb_seen, exp_stb);
    chk(ctrl == exp_ctrl, (nfall == 16) ? "R3 word" : "R7 word kept", ctrl, exp_ctrl);
    chk(srst_seen == ((nfall == 16 && word[0]) ? 1 : 0), "R9 stat reset", srst_seen,
        (nfall == 16 && word[0]) ? 1 : 0);
    chk_decode();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk(ctrl == 16'hE000, "R1 ctrl reset", ctrl, 16'hE000);
    chk({sdo_oe, ctrl_stb, stat_rst} == 3'b000, "R1 outputs reset", {sdo_oe, ctrl_stb, stat_rst}, 0);
    chk_decode();

    for (int n = 0; n <= 20; n++) begin
      logic [15:0] w;
      w = 16'(n * 16'h1357) ^ 16'hA5C3;
      frame(n, w, ~w ^ 16'(n));
    end

    for (int b = 0; b < 16; b++) frame(16, 16'(1) << b, 16'h8000 >> b);
    frame(16, 16'hFFFF, 16'h5AA5);
    frame(0, 16'h0000, 16'h0001);
    frame(0, 16'h0000, 16'h0000);
    frame(16, 16'h0000, 16'hC33C);

    stb_seen = 0;
    for (int i = 0; i < 5; i++) begin
      sdi = i[0];
      @(negedge clk) sclk = 1;
      settle();
      chk(sdo_oe == 1'b0, "R8 oe idle", sdo_oe, 0);
      @(negedge clk) sclk = 0;
      settle();
    end
    chk(stb_seen == 0, "R8 no strobe idle", stb_seen, 0);
    chk(ctrl == exp_ctrl, "R8 ctrl idle", ctrl, exp_ctrl);
    frame(16, 16'h6B2D, 16'h1F0E);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule